// File: doc/BRIEF.md
# MDIO Management Master Controller

This block is a register-mapped master for the two-wire MDIO management interface, using Clause 22 framing. Software reaches the registers of an external PHY through two 32-bit registers on a simple write-strobe bus with a combinational read port. The command register holds a 2-bit opcode, a 5-bit PHY address, a 5-bit register address and a 16-bit data field. Setting its start bit launches a frame. The block then drives the management clock and the data line, releases the line for the PHY's reply on reads, and clears the start bit when the last data bit has been sampled.

The configuration register sets the management clock divider. Each clock half-period lasts divider+1 reference cycles, so the clock runs at ref/(2×(divider+1)). The same register can drop the 32-bit preamble. On a read, the PHY's 16-bit reply replaces the command data field. A flag reports a PHY that failed to pull the line low on the second turnaround bit. The data line is modelled as a separate output, an output enable and an input, so a pad cell can combine them.

Top module: `mdio_master`

## Requirements
- R1: After reset, the command register (byte offset 0) reads 0x00000000 and the configuration register (byte offset 4) reads 0x00000311: divider 49, preamble on, framing-select bit 0 set. The management clock is high and the output enable is low.
- R2: A command write with bit 29 set while idle starts a frame and makes bit 29 read 1. Bit 29 reads 0 again from the cycle after the rising clock edge that samples the last data bit.
- R3: The management clock stays high while idle. Once a frame starts, the clock first falls divider+1 reference cycles after the launching edge and then toggles every divider+1 cycles. The divider is held in configuration bits 9:4.
- R4: With the preamble on, the line carries 64 bits in this order: 32 ones, start bits 0 then 1, opcode bits 27:26, PHY address bits 25:21 MSB first, register address bits 20:16 MSB first, two turnaround bits, then 16 data bits MSB first. Each bit changes only on a falling clock edge.
- R5: With configuration bit 12 set, the frame drops the 32 preamble ones and starts directly with the start bits, giving 32 bits.
- R6: For any opcode other than 10, the master drives every bit. The turnaround is 1 then 0, and the data bits come from command bits 15:0.
- R7: For opcode 10 (read), the output enable is low for both turnaround bits and all data bits. The data line is sampled on each rising clock edge, and the 16 sampled data bits, MSB first, land in command bits 15:0 when the frame ends.
- R8: Command bit 28 is set at the end of a read whose second turnaround bit was sampled high, and cleared at the end of a read sampled low and at the end of any non-read frame. Software writes to bit 28 have no effect.
- R9: While bit 29 reads 1, writes to either register are ignored.
- R10: The command data field and bit 28 keep their values for the whole frame and change only on the cycle in which bit 29 clears.
- R11: Configuration bits 0, 9:4 and 12 read back as written. All other configuration bits and command bits 31:30 read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | ADDR_W | Byte offset (0 command, 4 configuration) |
| bus_wdata | input | 32 | Register write data |
| bus_rdata | output | 32 | Register read data for bus_addr |
| mgmt_clk_o | output | 1 | Management clock to the PHYs |
| mgmt_dat_o | output | 1 | Data line value to drive |
| mgmt_dat_oe | output | 1 | Data line output enable |
| mgmt_dat_i | input | 1 | Data line value from the pad |

## Verification
Write frames with preamble and a small divider show that the header bit order, the driven turnaround and the data field all reach the line on falling edges. A read with a well-behaved PHY reply separates correct release and rising-edge sampling from a shifted or inverted capture. A read whose PHY holds the second turnaround bit high, followed by a write, checks that the fail flag both sets and clears. A read with the preamble suppressed and a divider of zero checks the short frame and the fastest clock. Another write with a larger divider checks the half-period count. Register writes issued mid-frame, and read-back of the fields during a frame, separate proper ignoring and end-of-frame update from early or late changes.

// File: rtl/mdio_pkg.sv
package mdio_pkg;

   localparam int CMD_GO_BIT   = 29;
   localparam int CMD_OP_LO    = 26;
   localparam int CFG_DIV_LO   = 4;
   localparam int CFG_NOPRE_BT = 12;

   typedef enum logic [1:0] {
      OP_NONE  = 2'b00,
      OP_WRITE = 2'b01,
      OP_READ  = 2'b10,
      OP_RSVD  = 2'b11
   } mdio_op_e;

   typedef struct packed {
      mdio_op_e    op;
      logic [4:0]  phy;
      logic [4:0]  regad;
      logic [15:0] data;
   } mdio_cmd_t;

endpackage

// File: rtl/mdio_clk_div.sv
module mdio_clk_div #(
   parameter int DIV_W = 6
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             run,
   input  logic [DIV_W-1:0] div,
   output logic             mdc,
   output logic             fall_stb,
   output logic             rise_stb
);

   logic [DIV_W-1:0] cnt_q;
   logic             at_end;

   assign at_end   = (cnt_q == div);
   assign fall_stb = run &&  mdc && at_end;
   assign rise_stb = run && !mdc && at_end;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cnt_q <= '0;
         mdc   <= 1'b1;
      end else if (!run) begin
         cnt_q <= '0;
         mdc   <= 1'b1;
      end else if (at_end) begin
         cnt_q <= '0;
         mdc   <= ~mdc;
      end else begin
         cnt_q <= cnt_q + 1'b1;
      end
   end

   // R3: the half-period counter never passes the divider during a frame
   a_r3_cnt_bound: assert property (@(posedge clk) disable iff (!rst_n)
      (run && $past(run)) |-> (cnt_q <= div));

endmodule

// File: rtl/mdio_frame_seq.sv
module mdio_frame_seq
   import mdio_pkg::*;
#(
   parameter int PRE_LEN = 32
) (
   input  logic        clk,
   input  logic        rst_n,
   input  logic        launch,
   input  mdio_cmd_t   cmd,
   input  logic        pre_off,
   input  logic        fall_stb,
   input  logic        rise_stb,
   input  logic        mdi,
   input  logic        mdc,
   output logic        active,
   output logic        mdo,
   output logic        mdo_oe,
   output logic        finish,
   output logic [15:0] cap_data,
   output logic        cap_fail
);

   localparam int FRAME_LEN = PRE_LEN + 32;
   localparam int IDX_W     = $clog2(FRAME_LEN + 1);
   localparam int PAD_LEN   = 1 << IDX_W;
   localparam logic [IDX_W-1:0] HDR_IDX  = IDX_W'(PRE_LEN);
   localparam logic [IDX_W-1:0] TA1_IDX  = IDX_W'(PRE_LEN + 14);
   localparam logic [IDX_W-1:0] TA2_IDX  = IDX_W'(PRE_LEN + 15);
   localparam logic [IDX_W-1:0] DAT_IDX  = IDX_W'(PRE_LEN + 16);
   localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(FRAME_LEN - 1);

   logic [IDX_W-1:0]   nxt_q;
   logic [IDX_W-1:0]   cur_q;
   logic [15:0]        sh_q;
   logic               fail_q;
   logic               is_rd;
   logic [31:0]        hdr;
   logic [PAD_LEN-1:0] bits_r;

   assign is_rd = (cmd.op == OP_READ);

   // bits_r[i] is the i-th bit placed on the line, preamble ones first
   always_comb begin
      hdr = {2'b01, cmd.op, cmd.phy, cmd.regad,
             (is_rd ? 2'b11 : 2'b10),
             (is_rd ? 16'hFFFF : cmd.data)};
      bits_r = '1;
      for (int i = 0; i < 32; i++) begin
         bits_r[PRE_LEN + i] = hdr[31 - i];
      end
   end

   assign finish   = active && rise_stb && (cur_q == LAST_IDX);
   assign cap_data = {sh_q[14:0], mdi};
   assign cap_fail = fail_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         active <= 1'b0;
         mdo    <= 1'b1;
         mdo_oe <= 1'b0;
         nxt_q  <= '0;
         cur_q  <= '0;
         sh_q   <= '0;
         fail_q <= 1'b0;
      end else if (launch) begin
         active <= 1'b1;
         nxt_q  <= pre_off ? HDR_IDX : '0;
         mdo    <= 1'b1;
         mdo_oe <= 1'b0;
         fail_q <= 1'b0;
      end else if (active && fall_stb) begin
         cur_q  <= nxt_q;
         nxt_q  <= nxt_q + 1'b1;
         mdo    <= bits_r[nxt_q];
         mdo_oe <= !(is_rd && (nxt_q >= TA1_IDX));
      end else if (active && rise_stb) begin
         if (is_rd && (cur_q == TA2_IDX)) begin
            fail_q <= mdi;
         end
         if (is_rd && (cur_q >= DAT_IDX)) begin
            sh_q <= {sh_q[14:0], mdi};
         end
         if (finish) begin
            active <= 1'b0;
            mdo_oe <= 1'b0;
            mdo    <= 1'b1;
         end
      end
   end

   // R7: the line stays released through turnaround and data of a read
   a_r7_read_tristate: assert property (@(posedge clk) disable iff (!rst_n)
      (active && is_rd && (cur_q >= TA1_IDX)) |-> !mdo_oe);

   // R4: the driven bit only moves when the clock falls or the frame ends
   a_r4_mdo_on_fall: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(mdo) |-> ($fell(mdc) || $fell(active)));

endmodule

// File: rtl/mdio_master.sv
module mdio_master
   import mdio_pkg::*;
#(
   parameter int ADDR_W  = 4,
   parameter int DIV_W   = 6,
   parameter int DIV_RST = 49,
   parameter int PRE_LEN = 32
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              bus_wr,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic [31:0]       bus_wdata,
   output logic [31:0]       bus_rdata,
   output logic              mgmt_clk_o,
   output logic              mgmt_dat_o,
   output logic              mgmt_dat_oe,
   input  logic              mgmt_dat_i
);

   localparam logic [ADDR_W-1:0] CMD_OFS = '0;
   localparam logic [ADDR_W-1:0] CFG_OFS = ADDR_W'(4);

   if (DIV_W < 1 || DIV_W > 6) begin : g_chk_div_w
      $error("mdio_master: DIV_W must lie in 1..6");
   end
   if (DIV_RST < 0 || DIV_RST >= (1 << DIV_W)) begin : g_chk_div_rst
      $error("mdio_master: DIV_RST does not fit DIV_W");
   end
   if (ADDR_W < 3) begin : g_chk_addr
      $error("mdio_master: ADDR_W too small for offset 4");
   end
   if (PRE_LEN < 1 || PRE_LEN > 32) begin : g_chk_pre
      $error("mdio_master: PRE_LEN must lie in 1..32");
   end

   mdio_cmd_t        cmd_q;
   logic             fail_q;
   logic [DIV_W-1:0] div_q;
   logic             nopre_q;
   logic             c22_q;
   logic             busy;
   logic             launch;
   logic             sel_cmd;
   logic             sel_cfg;
   logic             fall_stb;
   logic             rise_stb;
   logic             finish;
   logic [15:0]      cap_data;
   logic             cap_fail;
   logic [5:0]       div_rd;
   logic             wdata_unused;

   assign sel_cmd      = (bus_addr == CMD_OFS);
   assign sel_cfg      = (bus_addr == CFG_OFS);
   assign launch       = bus_wr && sel_cmd && !busy && bus_wdata[CMD_GO_BIT];
   assign div_rd       = 6'(div_q);
   assign wdata_unused = ^bus_wdata;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cmd_q   <= '0;
         fail_q  <= 1'b0;
         div_q   <= DIV_W'(DIV_RST);
         nopre_q <= 1'b0;
         c22_q   <= 1'b1;
      end else if (!busy) begin
         if (bus_wr && sel_cmd) begin
            cmd_q.op    <= mdio_op_e'(bus_wdata[CMD_OP_LO +: 2]);
            cmd_q.phy   <= bus_wdata[25:21];
            cmd_q.regad <= bus_wdata[20:16];
            cmd_q.data  <= bus_wdata[15:0];
         end
         if (bus_wr && sel_cfg) begin
            div_q   <= bus_wdata[CFG_DIV_LO +: DIV_W];
            nopre_q <= bus_wdata[CFG_NOPRE_BT];
            c22_q   <= bus_wdata[0];
         end
      end else if (finish) begin
         if (cmd_q.op == OP_READ) begin
            cmd_q.data <= cap_data;
            fail_q     <= cap_fail;
         end else begin
            fail_q     <= 1'b0;
         end
      end
   end

   always_comb begin
      bus_rdata = '0;
      if (sel_cmd) begin
         bus_rdata = {2'b00, busy, fail_q, cmd_q};
      end else if (sel_cfg) begin
         bus_rdata = {19'b0, nopre_q, 2'b00, div_rd, 3'b000, c22_q};
      end
   end

   mdio_clk_div #(
      .DIV_W (DIV_W)
   ) u_clk (
      .clk      (clk),
      .rst_n    (rst_n),
      .run      (busy),
      .div      (div_q),
      .mdc      (mgmt_clk_o),
      .fall_stb (fall_stb),
      .rise_stb (rise_stb)
   );

   mdio_frame_seq #(
      .PRE_LEN (PRE_LEN)
   ) u_seq (
      .clk      (clk),
      .rst_n    (rst_n),
      .launch   (launch),
      .cmd      (cmd_q),
      .pre_off  (nopre_q),
      .fall_stb (fall_stb),
      .rise_stb (rise_stb),
      .mdi      (mgmt_dat_i),
      .mdc      (mgmt_clk_o),
      .active   (busy),
      .mdo      (mgmt_dat_o),
      .mdo_oe   (mgmt_dat_oe),
      .finish   (finish),
      .cap_data (cap_data),
      .cap_fail (cap_fail)
   );

   // R2: outside a frame the line is released and the clock idles high
   a_r2_idle_released: assert property (@(posedge clk) disable iff (!rst_n)
      !busy |-> (!mgmt_dat_oe && mgmt_clk_o));

   // R9: command fields cannot change while a frame is running
   a_r9_fields_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && $past(busy)) |-> ($stable(cmd_q) && $stable(div_q) && $stable(nopre_q)));

   // R10: the fail flag and data field only move as the frame ends
   a_r10_result_at_end: assert property (@(posedge clk) disable iff (!rst_n)
      (!$stable(fail_q) || !$stable(cmd_q.data)) |-> ($fell(busy) || $past(!busy)));

endmodule

// File: tb/tb_mdio_master.sv
module tb_mdio_master;

   localparam int CLK_PER = 10;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        bus_wr = 1'b0;
   logic [3:0]  bus_addr = '0;
   logic [31:0] bus_wdata = '0;
   logic [31:0] bus_rdata;
   logic        mgmt_clk_o, mgmt_dat_o, mgmt_dat_oe;
   logic        phy_mdi = 1'b1;

   int n_chk = 0, n_bad = 0, cyc = 0;
   bit wd = 0;

   // behavioural reference state
   int m_busy, m_cnt, m_mdc, m_mdo, m_oe, m_pos;
   int m_op, m_phy, m_reg, m_data, m_fail, m_div, m_pre, m_c22;
   bit q_bits[$];
   bit q_oe[$];
   logic [15:0] phy_data = 16'h0;
   bit          bad_ta = 0;

   always #(CLK_PER/2) clk = ~clk;

   mdio_master dut (
      .clk         (clk),
      .rst_n       (rst_n),
      .bus_wr      (bus_wr),
      .bus_addr    (bus_addr),
      .bus_wdata   (bus_wdata),
      .bus_rdata   (bus_rdata),
      .mgmt_clk_o  (mgmt_clk_o),
      .mgmt_dat_o  (mgmt_dat_o),
      .mgmt_dat_oe (mgmt_dat_oe),
      .mgmt_dat_i  (phy_mdi)
   );

   function automatic void push_bit(bit b, bit oe);
      q_bits.push_back(b);
      q_oe.push_back(oe);
   endfunction

   function automatic void build_frame();
      bit rd;
      rd = (m_op == 2);
      q_bits.delete();
      q_oe.delete();
      if (m_pre == 0) repeat (32) push_bit(1'b1, 1'b1);
      push_bit(1'b0, 1'b1);
      push_bit(1'b1, 1'b1);
      for (int i = 1; i >= 0; i--) push_bit(m_op[i], 1'b1);
      for (int i = 4; i >= 0; i--) push_bit(m_phy[i], 1'b1);
      for (int i = 4; i >= 0; i--) push_bit(m_reg[i], 1'b1);
      if (rd) begin
         push_bit(1'b1, 1'b0);
         push_bit(1'b1, 1'b0);
         repeat (16) push_bit(1'b1, 1'b0);
      end else begin
         push_bit(1'b1, 1'b1);
         push_bit(1'b0, 1'b1);
         for (int i = 15; i >= 0; i--) push_bit(m_data[i], 1'b1);
      end
      m_pos = (m_pre != 0) ? 31 : -1;
   endfunction

   function automatic logic [31:0] exp_cmd();
      return {2'b00, m_busy[0], m_fail[0], m_op[1:0], m_phy[4:0], m_reg[4:0], m_data[15:0]};
   endfunction

   function automatic logic [31:0] exp_cfg();
      return {19'b0, m_pre[0], 2'b00, m_div[5:0], 3'b000, m_c22[0]};
   endfunction

   always @(posedge clk) begin
      int ob;
      if (!rst_n) begin
         m_busy = 0; m_cnt = 0; m_mdc = 1; m_mdo = 1; m_oe = 0; m_pos = 0;
         m_op = 0; m_phy = 0; m_reg = 0; m_data = 0; m_fail = 0;
         m_div = 49; m_pre = 0; m_c22 = 1;
      end else begin
         ob = m_busy;
         if (ob != 0) begin
            m_cnt++;
            if (m_cnt == m_div + 1) begin
               m_cnt = 0;
               if (m_mdc != 0) begin
                  m_mdc = 0;
                  m_mdo = q_bits.pop_front();
                  m_oe  = q_oe.pop_front();
                  m_pos++;
               end else begin
                  m_mdc = 1;
                  if (m_pos == 63) begin
                     m_busy = 0; m_oe = 0; m_mdo = 1;
                     if (m_op == 2) begin
                        m_data = phy_data;
                        m_fail = bad_ta;
                     end else begin
                        m_fail = 0;
                     end
                  end
               end
            end
         end else if (bus_wr) begin
            if (bus_addr == 4'd0) begin
               m_op = bus_wdata[27:26]; m_phy = bus_wdata[25:21];
               m_reg = bus_wdata[20:16]; m_data = bus_wdata[15:0];
               if (bus_wdata[29]) begin
                  m_busy = 1; m_cnt = 0;
                  build_frame();
               end
            end else if (bus_addr == 4'd4) begin
               m_div = bus_wdata[9:4]; m_pre = bus_wdata[12]; m_c22 = bus_wdata[0];
            end
         end
      end
   end

   // PHY reply, changed only away from the sampling edge
   always @(negedge clk) begin
      if (m_busy != 0 && m_op == 2 && m_pos == 47) phy_mdi <= bad_ta;
      else if (m_busy != 0 && m_op == 2 && m_pos >= 48 && m_pos <= 63) phy_mdi <= phy_data[63 - m_pos];
      else phy_mdi <= 1'b1;
   end

   task automatic chk(string tag, logic [31:0] got, logic [31:0] exp);
      n_chk++;
      if (got !== exp) begin
         n_bad++;
         $display("FAIL %s got=%h exp=%h", tag, got, exp);
      end
   endtask

   // cycle-by-cycle comparison against the reference
   always @(negedge clk) begin
      #2;
      if (rst_n && !wd) begin
         chk("R3 mgmt clock", {31'b0, mgmt_clk_o}, 32'(m_mdc));
         chk((m_op == 2) ? "R7 output enable" : "R6 output enable", {31'b0, mgmt_dat_oe}, 32'(m_oe));
         if (m_oe != 0) chk((m_pre != 0) ? "R5 line bit" : "R4 line bit", {31'b0, mgmt_dat_o}, 32'(m_mdo));
         if (bus_addr == 4'd0) chk("R10 cmd readback", bus_rdata, exp_cmd());
         if (bus_addr == 4'd4) chk("R9 cfg readback", bus_rdata, exp_cfg());
      end
   end

   always @(posedge clk) begin
      cyc++;
      if (cyc > 150000 && !wd) begin
         wd = 1;
         n_chk++; n_bad++;
         $display("FAIL R2 watchdog got=busy exp=idle");
         $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
         $finish;
      end
   end

   task automatic do_wr(logic [3:0] a, logic [31:0] d);
      @(negedge clk);
      bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
      @(negedge clk);
      bus_wr = 1'b0;
   endtask

   task automatic do_rd(logic [3:0] a, output logic [31:0] v);
      @(negedge clk);
      bus_addr = a;
      #1;
      v = bus_rdata;
   endtask

   task automatic wait_idle();
      logic [31:0] v;
      for (int i = 0; i < 20000; i++) begin
         do_rd(4'd0, v);
         if (!v[29]) break;
      end
   endtask

   function automatic logic [31:0] mk_cmd(bit go, logic [1:0] op, logic [4:0] phy,
                                          logic [4:0] rg, logic [15:0] d);
      return {2'b00, go, 1'b0, op, phy, rg, d};
   endfunction

   initial begin
      logic [31:0] v;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      // R1 reset state
      do_rd(4'd0, v); chk("R1 cmd reset", v, 32'h0);
      do_rd(4'd4, v); chk("R1 cfg reset", v, 32'h0000_0311);
      chk("R1 clock idle high", {31'b0, mgmt_clk_o}, 32'h1);
      chk("R1 line released", {31'b0, mgmt_dat_oe}, 32'h0);

      // R11 config round trip with stray bits
      do_wr(4'd4, 32'hA5A5_0C21);
      do_rd(4'd4, v); chk("R11 cfg fields", v, 32'h0000_0021);

      // R6 write frame, divider 2, preamble on
      do_wr(4'd0, mk_cmd(1'b1, 2'b01, 5'h13, 5'h0A, 16'hBEEF));
      do_rd(4'd0, v); chk("R2 busy after launch", {31'b0, v[29]}, 32'h1);
      // R9 writes during the frame are dropped
      do_wr(4'd0, mk_cmd(1'b1, 2'b10, 5'h1F, 5'h1F, 16'h0000));
      do_wr(4'd4, 32'h0000_13F0);
      do_rd(4'd0, v); chk("R9 cmd kept", v, 32'h2000_0000 | mk_cmd(1'b0, 2'b01, 5'h13, 5'h0A, 16'hBEEF));
      do_rd(4'd4, v); chk("R9 cfg kept", v, 32'h0000_0021);
      wait_idle();
      do_rd(4'd0, v); chk("R6 write done", v, mk_cmd(1'b0, 2'b01, 5'h13, 5'h0A, 16'hBEEF));

      // R7 read with a clean reply
      phy_data = 16'h1234; bad_ta = 0;
      do_wr(4'd0, mk_cmd(1'b1, 2'b10, 5'h01, 5'h02, 16'hAAAA));
      repeat (100) @(negedge clk);
      do_rd(4'd0, v); chk("R10 data held mid-frame", {16'h0, v[15:0]}, 32'h0000_AAAA);
      wait_idle();
      do_rd(4'd0, v); chk("R7 read data", {16'h0, v[15:0]}, 32'h0000_1234);
      chk("R8 fail clear on good reply", {31'b0, v[28]}, 32'h0);

      // R8 turnaround not released
      phy_data = 16'hC3A5; bad_ta = 1;
      do_wr(4'd0, mk_cmd(1'b1, 2'b10, 5'h07, 5'h11, 16'h0000));
      wait_idle();
      do_rd(4'd0, v); chk("R8 fail set", {31'b0, v[28]}, 32'h1);
      chk("R7 read data with fail", {16'h0, v[15:0]}, 32'h0000_C3A5);
      bad_ta = 0;
      // R8 software cannot touch bit 28
      do_wr(4'd0, 32'h1000_0000);
      do_rd(4'd0, v); chk("R8 bit 28 read-only", {31'b0, v[28]}, 32'h1);
      do_wr(4'd0, mk_cmd(1'b1, 2'b01, 5'h02, 5'h03, 16'h5A5A));
      wait_idle();
      do_rd(4'd0, v); chk("R8 fail cleared by write", {31'b0, v[28]}, 32'h0);

      // R5 preamble suppressed, divider 0
      do_wr(4'd4, 32'h0000_1001);
      do_rd(4'd4, v); chk("R11 suppress bit", v, 32'h0000_1001);
      phy_data = 16'h8001;
      do_wr(4'd0, mk_cmd(1'b1, 2'b10, 5'h1E, 5'h01, 16'h0000));
      wait_idle();
      do_rd(4'd0, v); chk("R5 short read data", {16'h0, v[15:0]}, 32'h0000_8001);

      // R3 divider 5 with preamble, write frame
      do_wr(4'd4, 32'h0000_0051);
      do_wr(4'd0, mk_cmd(1'b1, 2'b11, 5'h15, 5'h0C, 16'h0F0F));
      wait_idle();
      do_rd(4'd0, v); chk("R3 frame done at div 5", {31'b0, v[29]}, 32'h0);
      chk("R11 top bits zero", {30'b0, v[31:30]}, 32'h0);

      repeat (4) @(negedge clk);
      $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
   end

endmodule